// File: doc/BRIEF.md
# Video Start Code Scanner

This block sits in a compressed video byte stream between the source buffer and the decoder. Each byte crosses it in the same cycle under a valid/ready handshake. While the bytes pass through, the block looks for the start-code prefix: two or more zero bytes followed by a `0x01` byte. The byte after that prefix is the code value. Software arms a search by giving a target code value and a mode. The block reports a match only when it is armed and the code value equals the target. A match ends the search and disarms the block.

The two modes differ in what happens after a match. A non-blocking search only pulses the match flag and reports the matched code, and bytes keep flowing to the decoder. A blocking search also raises a hold signal. Hold closes the handshake in both directions and stays up until software pulses resume. The code values used in practice are `0xB3` (sequence), `0xB8` (group) and `0x00` (picture). A sequence-code search in blocking mode is the usual way to reacquire the stream quickly, for example after a channel change or for a still capture.

Top module: `sc_scanner`

## Requirements
- R1: While `rst_n` is low, `match`, `hold` and `armed` are 0 and `match_code` is `0x00`.
- R2: While `hold` is 0, `out_data` equals `in_data`, `out_valid` equals `in_valid` and `in_ready` equals `out_ready`, with no register in the path. A byte is accepted in a cycle where `in_valid` and `in_ready` are both 1.
- R3: A start code is the accepted byte sequence `0x00 0x00 0x01 C`. If the block is armed and C equals the armed target, `match` is 1 for exactly the one cycle after the edge that accepts C, and from that cycle on `match_code` holds C.
- R4: While the block is not armed, no start code raises `match`.
- R5: A run of any length of at least two zero bytes, followed by `0x01`, is a valid prefix.
- R6: A `0x01` byte that follows fewer than two zero bytes does not form a prefix, so the byte after it is not treated as a code value.
- R7: A pulse on `arm` loads `arm_code` as the target and `arm_block` as the mode (1 = blocking), and sets `armed` from the next cycle. A match clears `armed` in the same cycle that `match` rises, so a later start code with the same value does not match.
- R8: In blocking mode, `hold` rises together with `match`. While `hold` is 1, `in_ready` and `out_valid` are 0. `hold` stays 1 until a pulse on `resume`, and it is 0 from the cycle after that pulse.
- R9: In non-blocking mode, a match leaves `hold` at 0 and bytes keep flowing.
- R10: A start code whose value differs from the target neither matches nor disarms the block.
- R11: A byte that is offered but not accepted, because `in_valid` or `in_ready` is 0, does not change the prefix detector.
- R12: A code byte of `0x00` also counts as the first zero of the next prefix. So `0x00 0x00 0x01 0x00 0x00 0x01 0xB3` holds two start codes, picture and then sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_data | input | 8 | Stream byte from the source |
| in_valid | input | 1 | Source byte valid |
| in_ready | output | 1 | Scanner can take a byte |
| out_data | output | 8 | Byte to the decoder |
| out_valid | output | 1 | Byte to the decoder valid |
| out_ready | input | 1 | Decoder can take a byte |
| arm | input | 1 | One-cycle pulse that starts a search |
| arm_code | input | 8 | Target code value taken on `arm` |
| arm_block | input | 1 | Mode taken on `arm`: 1 = blocking, 0 = non-blocking |
| resume | input | 1 | One-cycle pulse that releases the hold |
| match | output | 1 | One-cycle match pulse |
| match_code | output | 8 | Code value of the latest match |
| hold | output | 1 | Decoder flow halted after a blocking match |
| armed | output | 1 | A search is pending |

## Verification
The bench arms every supported target in both modes and sends all 256 code values after a prefix. A comparator that ignored the target, or one that failed to disarm after a match, would show up there as extra or missing match pulses. Zero runs of length zero to five before `0x01` show whether the zero counter saturates: a detector that needs exactly two zeros would miss stuffed prefixes, and one that needs only one zero would match on a lone zero. Stalled handshakes and a picture code followed directly by another prefix expose a detector that advances on bytes that were not accepted, or one that throws away a zero code byte. In blocking mode the bench checks that the handshake stays closed until resume; a hold that drops early would let bytes through.

// File: rtl/sc_pkg.sv
`timescale 1ns/1ps
package sc_pkg;
  localparam int BYTE_W = 8;
  localparam logic [BYTE_W-1:0] PFX_MARK = 8'h01;

  typedef struct packed {
    logic [BYTE_W-1:0] code;
    logic              block;
  } search_cmd_t;
endpackage

// File: rtl/sc_prefix_det.sv
`timescale 1ns/1ps
module sc_prefix_det
  import sc_pkg::*;
#(
  parameter int ZERO_RUN = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              beat,
  input  logic [BYTE_W-1:0] byte_in,
  output logic              code_slot
);
  localparam int ZW = $clog2(ZERO_RUN + 1);
  localparam logic [ZW-1:0] ZMAX = ZW'(ZERO_RUN);

  logic [ZW-1:0] zcnt_q, zcnt_d;
  logic          pfx_q, pfx_d;
  logic          is_zero;

  assign is_zero   = (byte_in == '0);
  assign code_slot = pfx_q;

  always_comb begin
    zcnt_d = zcnt_q;
    pfx_d  = pfx_q;
    if (beat) begin
      if (pfx_q) begin
        pfx_d  = 1'b0;
        zcnt_d = is_zero ? ZW'(1) : '0;
      end else if (is_zero) begin
        zcnt_d = (zcnt_q == ZMAX) ? ZMAX : zcnt_q + ZW'(1);
      end else if (byte_in == PFX_MARK && zcnt_q == ZMAX) begin
        pfx_d  = 1'b1;
        zcnt_d = '0;
      end else begin
        zcnt_d = '0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      zcnt_q <= '0;
      pfx_q  <= 1'b0;
    end else if (beat) begin
      zcnt_q <= zcnt_d;
      pfx_q  <= pfx_d;
    end
  end
endmodule

// File: rtl/sc_match_ctl.sv
`timescale 1ns/1ps
module sc_match_ctl
  import sc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              arm,
  input  logic [BYTE_W-1:0] arm_code,
  input  logic              arm_block,
  input  logic              resume,
  input  logic              beat,
  input  logic [BYTE_W-1:0] byte_in,
  input  logic              code_slot,
  output logic              match,
  output logic [BYTE_W-1:0] match_code,
  output logic              hold,
  output logic              armed
);
  search_cmd_t       cmd_q, cmd_d;
  logic              armed_q, armed_d;
  logic              match_q, match_d;
  logic [BYTE_W-1:0] code_q, code_d;
  logic              hold_q, hold_d;
  logic              hit;
  logic              cmd_en, code_en;

  assign hit     = beat && code_slot && armed_q && (byte_in == cmd_q.code);
  assign cmd_en  = arm;
  assign code_en = hit;

  always_comb begin
    cmd_d.code  = arm_code;
    cmd_d.block = arm_block;
    match_d     = hit;
    code_d      = byte_in;
    if (arm)      armed_d = 1'b1;
    else if (hit) armed_d = 1'b0;
    else          armed_d = armed_q;
    if (hit && cmd_q.block) hold_d = 1'b1;
    else if (resume)        hold_d = 1'b0;
    else                    hold_d = hold_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q   <= '0;
      armed_q <= 1'b0;
      match_q <= 1'b0;
      code_q  <= '0;
      hold_q  <= 1'b0;
    end else begin
      armed_q <= armed_d;
      match_q <= match_d;
      hold_q  <= hold_d;
      if (cmd_en)  cmd_q  <= cmd_d;
      if (code_en) code_q <= code_d;
    end
  end

  assign match      = match_q;
  assign match_code = code_q;
  assign hold       = hold_q;
  assign armed      = armed_q;
endmodule

// File: rtl/sc_flow_gate.sv
`timescale 1ns/1ps
module sc_flow_gate
  import sc_pkg::*;
(
  input  logic [BYTE_W-1:0] in_data,
  input  logic              in_valid,
  output logic              in_ready,
  output logic [BYTE_W-1:0] out_data,
  output logic              out_valid,
  input  logic              out_ready,
  input  logic              hold,
  output logic              beat
);
  assign out_data  = in_data;
  assign out_valid = in_valid && !hold;
  assign in_ready  = out_ready && !hold;
  assign beat      = in_valid && out_ready && !hold;
endmodule

// File: rtl/sc_scanner.sv
`timescale 1ns/1ps
module sc_scanner
  import sc_pkg::*;
#(
  parameter int ZERO_RUN = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BYTE_W-1:0] in_data,
  input  logic              in_valid,
  output logic              in_ready,
  output logic [BYTE_W-1:0] out_data,
  output logic              out_valid,
  input  logic              out_ready,
  input  logic              arm,
  input  logic [BYTE_W-1:0] arm_code,
  input  logic              arm_block,
  input  logic              resume,
  output logic              match,
  output logic [BYTE_W-1:0] match_code,
  output logic              hold,
  output logic              armed
);
  logic beat;
  logic code_slot;
  logic hold_i;

  sc_flow_gate u_gate (
    .in_data   (in_data),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .out_data  (out_data),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .hold      (hold_i),
    .beat      (beat)
  );

  sc_prefix_det #(.ZERO_RUN(ZERO_RUN)) u_pfx (
    .clk       (clk),
    .rst_n     (rst_n),
    .beat      (beat),
    .byte_in   (in_data),
    .code_slot (code_slot)
  );

  sc_match_ctl u_ctl (
    .clk        (clk),
    .rst_n      (rst_n),
    .arm        (arm),
    .arm_code   (arm_code),
    .arm_block  (arm_block),
    .resume     (resume),
    .beat       (beat),
    .byte_in    (in_data),
    .code_slot  (code_slot),
    .match      (match),
    .match_code (match_code),
    .hold       (hold_i),
    .armed      (armed)
  );

  assign hold = hold_i;
endmodule

// File: rtl/sc_scanner_chk.sv
`timescale 1ns/1ps
module sc_scanner_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [7:0] in_data,
  input logic       in_valid,
  input logic       in_ready,
  input logic [7:0] out_data,
  input logic       out_valid,
  input logic       out_ready,
  input logic       arm,
  input logic       resume,
  input logic       match,
  input logic       hold,
  input logic       armed
);
  assert_pass_through_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !hold |-> (out_data == in_data && out_valid == in_valid && in_ready == out_ready));

  assert_match_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
    match |=> !match);

  assert_match_needs_arm_R4: assert property (@(posedge clk) disable iff (!rst_n)
    match |-> $past(armed));

  assert_disarm_R7: assert property (@(posedge clk) disable iff (!rst_n)
    match |-> (!armed || $past(arm)));

  assert_hold_gates_R8: assert property (@(posedge clk) disable iff (!rst_n)
    hold |-> (!in_ready && !out_valid));

  assert_hold_rise_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hold) |-> match);

  assert_hold_keep_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (hold && !resume) |=> hold);

  assert_hold_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(hold) |-> $past(resume));
endmodule

bind sc_scanner sc_scanner_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_data   (in_data),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .out_data  (out_data),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .arm       (arm),
  .resume    (resume),
  .match     (match),
  .hold      (hold),
  .armed     (armed)
);

// File: tb/tb_sc_scanner.sv
`timescale 1ns/1ps
module tb_sc_scanner;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] in_data = '0;
  logic       in_valid = 1'b0;
  logic       in_ready;
  logic [7:0] out_data;
  logic       out_valid;
  logic       out_ready = 1'b1;
  logic       arm = 1'b0;
  logic [7:0] arm_code = '0;
  logic       arm_block = 1'b0;
  logic       resume = 1'b0;
  logic       match;
  logic [7:0] match_code;
  logic       hold;
  logic       armed;

  always #2.5 clk = ~clk;

  sc_scanner dut (.*);

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  // reference state, derived from the requirements
  int         m_z = 0;
  bit         m_pf = 1'b0;
  bit         m_armed = 1'b0;
  bit         m_blk = 1'b0;
  bit         m_hold = 1'b0;
  logic [7:0] m_tgt = '0;
  logic [7:0] m_code = '0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic push(input logic [7:0] b, input string req);
    bit hit;
    @(negedge clk);
    in_valid = 1'b1;
    in_data  = b;
    #1;
    chk("R2 out_valid", out_valid, 1);
    chk("R2 out_data", out_data, b);
    chk("R2 in_ready", in_ready, 1);
    @(negedge clk);
    in_valid = 1'b0;
    hit = m_pf && m_armed && (b == m_tgt);
    if (m_pf) begin
      m_pf = 1'b0;
      m_z  = (b == 8'h00) ? 1 : 0;
    end else if (b == 8'h00) begin
      m_z = (m_z < 2) ? m_z + 1 : 2;
    end else if (b == 8'h01 && m_z == 2) begin
      m_pf = 1'b1;
      m_z  = 0;
    end else begin
      m_z = 0;
    end
    if (hit) begin
      m_armed = 1'b0;
      m_code  = b;
      if (m_blk) m_hold = 1'b1;
    end
    chk({req, " match"}, match, hit);
    chk({req, " match_code"}, match_code, m_code);
    chk({req, " hold"}, hold, m_hold);
    chk({req, " armed"}, armed, m_armed);
  endtask

  task automatic start_code(input logic [7:0] c, input string req);
    push(8'h00, req);
    push(8'h00, req);
    push(8'h01, req);
    push(c, req);
  endtask

  task automatic do_arm(input logic [7:0] code, input bit blk);
    @(negedge clk);
    arm = 1'b1; arm_code = code; arm_block = blk;
    @(negedge clk);
    arm = 1'b0;
    m_armed = 1'b1; m_tgt = code; m_blk = blk;
    chk("R7 armed after arm", armed, 1);
  endtask

  task automatic do_resume();
    @(negedge clk);
    in_valid = 1'b1;
    #1;
    chk("R8 in_ready while hold", in_ready, 0);
    chk("R8 out_valid while hold", out_valid, 0);
    @(negedge clk);
    chk("R8 hold kept", hold, 1);
    in_valid = 1'b0;
    resume = 1'b1;
    @(negedge clk);
    resume = 1'b0;
    m_hold = 1'b0;
    chk("R8 hold released", hold, 0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 5);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 match", match, 0);
    chk("R1 hold", hold, 0);
    chk("R1 armed", armed, 0);
    chk("R1 match_code", match_code, 0);
    rst_n = 1'b1;

    // R4: unarmed scanner reports nothing
    start_code(8'hB3, "R4");
    start_code(8'h00, "R4");

    // R3 R9 R8 R10 R12: every target and mode against all code values
    for (int t = 0; t < 3; t++) begin
      for (int bk = 0; bk < 2; bk++) begin
        logic [7:0] tgt;
        tgt = (t == 0) ? 8'hB3 : (t == 1) ? 8'hB8 : 8'h00;
        do_arm(tgt, bit'(bk));
        for (int c = 0; c < 256; c++) begin
          start_code(8'(c), "R3 R9 R10 R12");
          if (!m_armed) begin
            if (m_hold) do_resume();
            do_arm(tgt, bit'(bk));
          end
        end
      end
    end

    // R7: disarm after a match, same code no longer matches
    do_arm(8'hB8, 1'b0);
    start_code(8'hB8, "R7");
    start_code(8'hB8, "R7");

    // R5 R6: zero-run length sweep before 0x01
    for (int n = 0; n < 6; n++) begin
      if (!m_armed) do_arm(8'hB3, 1'b0);
      push(8'hFF, "R5 R6");
      for (int k = 0; k < n; k++) push(8'h00, "R5 R6");
      push(8'h01, "R5 R6");
      push(8'hB3, "R5 R6");
    end

    // R6: 0x01 after a broken zero run
    if (!m_armed) do_arm(8'hB3, 1'b0);
    push(8'h00, "R6"); push(8'h05, "R6"); push(8'h00, "R6");
    push(8'h01, "R6"); push(8'hB3, "R6");
    push(8'h00, "R6"); push(8'h00, "R6"); push(8'h05, "R6");
    push(8'h01, "R6"); push(8'hB3, "R6");

    // R11: stalled 0x01 is not consumed
    if (!m_armed) do_arm(8'hB3, 1'b0);
    push(8'hFF, "R11"); push(8'h00, "R11"); push(8'h00, "R11");
    @(negedge clk);
    out_ready = 1'b0; in_valid = 1'b1; in_data = 8'h01;
    #1;
    chk("R11 in_ready stalled", in_ready, 0);
    repeat (3) @(negedge clk);
    in_valid = 1'b0; out_ready = 1'b1;
    push(8'hB3, "R11");
    start_code(8'hB3, "R11");

    // R12: picture code immediately followed by a sequence code
    do_arm(8'hB3, 1'b1);
    start_code(8'h00, "R12");
    push(8'h00, "R12"); push(8'h01, "R12"); push(8'hB3, "R12");
    chk("R12 match seen", match_code, 8'hB3);
    if (m_hold) do_resume();

    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule